// File: doc/BRIEF.md
# Serial Converter Read Controller

This block is the host side of a link to an 8-bit serial analog-to-digital converter that is driven by only an active-low select line and a serial clock, and that answers on one serial data line. A single-cycle request starts an access. The controller selects the converter and waits out the select-to-clock setup time. It then issues eight clock pulses with a fixed high width and a fixed low width, and it shifts in the byte most significant bit first. The first bit is already present on the data line before the first clock pulse. The byte that arrives during an access is the result of the conversion that the previous access started.

The falling edge of the eighth pulse starts the converter's hold and conversion. The controller then waits out the conversion time before it offers the captured byte on a valid/ready output. A mode pin, sampled when the access is launched, chooses how the wait is spent: with select kept low and the clock parked low, or with select released high. Requests that arrive during an access or during the wait are kept as a single pending request. A pending request is never issued early, so a conversion in progress is never cut short. All timing is counted in host clock cycles and set by parameters.

Back-pressure rules for the result port: once `res_valid` is high it stays high, and `res_data` holds its value, until a cycle in which `res_ready` is high. No new access is launched while a result is still waiting, so no captured byte is ever lost.

Top module: `adcrd_top`

## Requirements
- R1: After reset `adc_cs_n` is 1, `adc_sclk` is 0, `busy` is 0 and `res_valid` is 0.
- R2: A `start_req` seen while idle, with no result waiting, drives `adc_cs_n` low from the next cycle. `adc_sclk` then stays 0 for exactly SETUP_CYC cycles before its first rise.
- R3: An access produces exactly eight `adc_sclk` pulses, each high for HALF_CYC cycles. The low gap between two pulses is HALF_CYC cycles, and `adc_sclk` is high only while `adc_cs_n` is low.
- R4: `adc_sdo` is sampled in the last host cycle of each high phase. The first sample becomes bit 7 of the byte and the eighth sample becomes bit 0.
- R5: After the eighth falling edge, `adc_sclk` stays 0 for CONV_CYC cycles. During those cycles `adc_cs_n` is 0 if `park_cs_high` was 0 at launch, and 1 if it was 1.
- R6: `res_valid` rises in the cycle after the conversion wait ends. `res_data` then holds the byte captured in that access, which is the previous conversion's result.
- R7: While `res_valid` is 1 and `res_ready` is 0, `res_valid` and `res_data` hold their values, and no new access is launched.
- R8: `busy` is 1 from the cycle after an accepted `start_req` until the conversion wait has ended. It is also 1 while a request is pending.
- R9: A `start_req` that arrives during an access or its wait is kept pending and launched only after the wait. Any number of such requests merge into one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Single-cycle request to perform one access |
| park_cs_high | input | 1 | 1: release select during the conversion wait; 0: keep select low, clock low |
| busy | output | 1 | Access, conversion wait or pending request in progress |
| adc_cs_n | output | 1 | Active-low converter select |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_sdo | input | 1 | Serial data from the converter |
| res_valid | output | 1 | Captured byte available |
| res_ready | input | 1 | Consumer accepts the byte |
| res_data | output | 8 | Captured byte, MSB received first |

## Verification
The inline assertions check the following on every cycle:
- the clock is never high with select released, and select never falls with the clock high;
- select falls only from the idle state, so a conversion is never re-entered;
- a request during an access always becomes pending;
- a held result stays frozen under back-pressure;
- the timer and shifter hold their state between events.

The exact cycle counts of the setup, the pulse widths and the conversion wait, the bit order of the capture, and the one-access lag of the returned data can only be shown by the bench. It does this by running a converter model alongside a timeline-based reference model across both wait modes, merged requests and a stalled consumer.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HI,
    ST_LO,
    ST_CONV
  } adcrd_st_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/adcrd_timer.sv
module adcrd_timer #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  AST_TMR_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && done) |=> done); // R3

endmodule

// File: rtl/adcrd_shift.sv
module adcrd_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          bit_in,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  data <= '0;
    else if (en) data <= {data[DW-2:0], bit_in};
  end

  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(data)); // R4

endmodule

// File: rtl/adcrd_top.sv
module adcrd_top
  import adcrd_pkg::*;
#(
  parameter int DW        = 8,
  parameter int SETUP_CYC = 176,
  parameter int HALF_CYC  = 52,
  parameter int CONV_CYC  = 2200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic          park_cs_high,
  output logic          busy,
  output logic          adc_cs_n,
  output logic          adc_sclk,
  input  logic          adc_sdo,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [DW-1:0] res_data
);
  localparam int MAXC = max3(SETUP_CYC, HALF_CYC, CONV_CYC);
  localparam int TW   = $clog2(MAXC + 1);
  localparam int BW   = $clog2(DW);
  localparam logic [TW-1:0] LD_SETUP = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] LD_HALF  = TW'(HALF_CYC - 1);
  localparam logic [TW-1:0] LD_CONV  = TW'(CONV_CYC - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  adcrd_st_e     st, st_nx;
  logic          pend, park_q;
  logic [BW-1:0] bitcnt;
  logic          launch, tmr_done, tmr_load, shift_en;
  logic [TW-1:0] tmr_val;

  assign launch = (st == ST_IDLE) && (pend || start_req) && !res_valid;

  always_comb begin
    st_nx    = st;
    tmr_load = 1'b0;
    tmr_val  = LD_HALF;
    shift_en = 1'b0;
    unique case (st)
      ST_IDLE: if (launch) begin
        st_nx = ST_SETUP; tmr_load = 1'b1; tmr_val = LD_SETUP;
      end
      ST_SETUP: if (tmr_done) begin
        st_nx = ST_HI; tmr_load = 1'b1;
      end
      ST_HI: if (tmr_done) begin
        shift_en = 1'b1;
        tmr_load = 1'b1;
        if (bitcnt == LAST_BIT) begin
          st_nx = ST_CONV; tmr_val = LD_CONV;
        end else begin
          st_nx = ST_LO;
        end
      end
      ST_LO: if (tmr_done) begin
        st_nx = ST_HI; tmr_load = 1'b1;
      end
      ST_CONV: if (tmr_done) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      pend      <= 1'b0;
      park_q    <= 1'b0;
      bitcnt    <= '0;
      res_valid <= 1'b0;
    end else begin
      st <= st_nx;
      if (launch) begin
        pend   <= 1'b0;
        park_q <= park_cs_high;
        bitcnt <= '0;
      end else begin
        if (start_req) pend <= 1'b1;
        if (shift_en)  bitcnt <= bitcnt + 1'b1;
      end
      if (st == ST_CONV && tmr_done)  res_valid <= 1'b1;
      else if (res_valid && res_ready) res_valid <= 1'b0;
    end
  end

  adcrd_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  adcrd_shift #(.DW(DW)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (shift_en),
    .bit_in (adc_sdo),
    .data   (res_data)
  );

  assign adc_cs_n = (st == ST_IDLE) || (st == ST_CONV && park_q);
  assign adc_sclk = (st == ST_HI);
  assign busy     = (st != ST_IDLE) || pend;

  AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    adc_sclk |-> !adc_cs_n); // R3
  AST_SETUP_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> !adc_sclk); // R2
  AST_NO_RESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> $past(st) == ST_IDLE); // R9
  AST_REQ_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE && start_req) |=> pend); // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data))); // R7
  AST_RESULT_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(st) == ST_CONV); // R6

endmodule

// File: tb/adcrd_top_tb.sv
module adcrd_top_tb;
  localparam int S = 5;
  localparam int H = 3;
  localparam int C = 12;
  localparam int T_CLK_END = S + 15*H;
  localparam int T_END     = T_CLK_END + C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0;
  logic park_cs_high = 1'b0;
  logic res_ready = 1'b1;
  logic busy, adc_cs_n, adc_sclk, res_valid;
  logic adc_sdo = 1'b0;
  logic [7:0] res_data;

  always #4 clk = ~clk;

  adcrd_top #(.DW(8), .SETUP_CYC(S), .HALF_CYC(H), .CONV_CYC(C)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .park_cs_high(park_cs_high),
    .busy(busy), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_sdo(adc_sdo),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, n_launch = 0;
  bit finished = 0;

  // converter model: previous-result shift-out, sample at eighth falling edge
  logic [7:0] ana = 8'h00;
  logic [7:0] conv_res = 8'h3C;
  logic [7:0] sh = 8'h00;
  int nf = 0;
  logic [7:0] exp_q[$];
  initial exp_q.push_back(8'h3C);

  always @(negedge adc_cs_n) begin
    #1; sh = conv_res; nf = 0; adc_sdo = sh[7]; n_launch++;
  end
  always @(negedge adc_sclk) begin
    #1; nf++;
    if (nf == 8) begin conv_res = ana; exp_q.push_back(ana); end
    else begin sh = {sh[6:0], 1'b0}; adc_sdo = sh[7]; end
  end

  // timeline reference model
  int tm = -1;
  bit m_pend = 0, m_rv = 0, m_park = 0, rv0, pd0;
  always @(posedge clk) begin
    if (!rst_n) begin tm = -1; m_pend = 0; m_rv = 0; end
    else begin
      rv0 = m_rv; pd0 = m_pend;
      if (rv0 && res_ready) begin
        m_rv = 0;
        if (exp_q.size() > 0) void'(exp_q.pop_front());
      end
      if (tm < 0) begin
        if ((pd0 || start_req) && !rv0) begin tm = 0; m_pend = 0; m_park = park_cs_high; end
        else if (start_req) m_pend = 1;
      end else begin
        if (start_req) m_pend = 1;
        tm++;
        if (tm == T_END) begin tm = -1; m_rv = 1; end
      end
    end
  end

  function automatic bit exp_cs_n();
    if (tm < 0) return 1'b1;
    if (tm >= T_CLK_END && m_park) return 1'b1;
    return 1'b0;
  endfunction
  function automatic bit exp_sclk();
    if (tm < S || tm >= T_CLK_END) return 1'b0;
    return (((tm - S) / H) % 2) == 0;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, expv, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !finished) begin
      check("R2/R5 cs_n", {7'd0, adc_cs_n}, {7'd0, exp_cs_n()});
      check("R3 sclk", {7'd0, adc_sclk}, {7'd0, exp_sclk()});
      check("R8 busy", {7'd0, busy}, {7'd0, (tm >= 0) || m_pend});
      check("R6/R7 res_valid", {7'd0, res_valid}, {7'd0, m_rv});
      if (res_valid && m_rv)
        check("R4/R6 res_data", res_data, (exp_q.size() > 0) ? exp_q[0] : 8'hxx);
    end
    if (cyc > 20000 && !finished) begin
      n_chk++; n_bad++; finished = 1;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask
  task automatic pulse_req();
    start_req = 1'b1; step(1); start_req = 1'b0;
  endtask
  task automatic wait_idle();
    for (int i = 0; i < 1000; i++) begin
      if (!busy && !res_valid) break;
      step(1);
    end
    step(2);
  endtask

  logic [7:0] held;
  initial begin
    step(3);
    // R1 reset values
    check("R1 cs_n", {7'd0, adc_cs_n}, 8'd1);
    check("R1 sclk", {7'd0, adc_sclk}, 8'd0);
    check("R1 busy", {7'd0, busy}, 8'd0);
    check("R1 res_valid", {7'd0, res_valid}, 8'd0);
    rst_n = 1'b1; step(2);

    // R2 R3 R4 R5 R6: clock-low wait, returns initial result
    ana = 8'h96; park_cs_high = 1'b0; pulse_req(); wait_idle();
    // R5: select released during wait; data of previous access
    ana = 8'h5A; park_cs_high = 1'b1; pulse_req(); wait_idle();
    // R9: several requests during access merge into one pending access
    ana = 8'hC3; park_cs_high = 1'b0; pulse_req(); step(20);
    pulse_req(); step(10); pulse_req(); step(S + 10);
    ana = 8'h01; wait_idle();
    check("R9 launches", n_launch[7:0], 8'd4);
    // R7: stalled consumer, request held until result taken
    res_ready = 1'b0; ana = 8'hFE; pulse_req();
    for (int i = 0; i < 400 && !res_valid; i++) step(1);
    held = res_data; pulse_req(); step(30);
    check("R7 data held", res_data, held);
    check("R7 no launch", n_launch[7:0], 8'd5);
    res_ready = 1'b1; ana = 8'h80; wait_idle();
    check("R9 pending launched", n_launch[7:0], 8'd6);
    park_cs_high = 1'b1; ana = 8'h7F; pulse_req(); wait_idle();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule